// File: doc/BRIEF.md
# Accuracy-Aware Memory Request Scheduler

This block holds a small pool of pending memory requests and, on every DRAM bus cycle, names one of them to be served next. Each request carries a bank, a row, a flag telling whether it is a demand or a prefetch, and the ID of the core that issued it. When a request is accepted it receives an arrival sequence number. From outside the block receives, for each core, a prefetch accuracy in percent. For each bank it also receives the row that is currently open and a flag that says whether any row is open.

Every entry is given three class bits, and each cycle they are worked out again from the current inputs. A demand is always critical. A prefetch is critical only when its core's accuracy reaches the promotion threshold. An entry is a row hit when its row is the open row of its bank. A demand is urgent when its core's accuracy is below the threshold. The winner is found by comparing critical, then row hit, then urgent, and then the lowest arrival number. A demand whose bank and row match a queued prefetch is not stored as a new entry. The prefetch entry is turned into a demand instead, and it keeps its place in arrival order. When the bus-cycle strobe is high, the winner is registered onto the grant outputs and its slot is freed.

Top module: `acc_sched`

## Requirements
- R1: When no entry is valid, a bus tick produces no grant, and a grant never names an entry that was not valid at the deciding edge.
- R2: A demand is always critical. A prefetch is critical only if its core's accuracy is at least 85. Each core's accuracy is a 7-bit unsigned percent at `acc_pct[c*7 +: 7]`; 85 counts as high and 84 counts as low.
- R3: A demand from a core whose accuracy is below 85 is urgent. A demand from a core at 85 or above is not urgent.
- R4: The winner is chosen in this order of precedence: critical first, then row hit, then urgent, then arrival order.
- R5: An entry is a row hit only when `open_vld[bank]` is 1 and `open_row[bank*ROW_W +: ROW_W]` equals the entry's row. A bank whose row is not open gives no hits.
- R6: Among entries of equal class, the one that arrived first wins, whatever its slot index.
- R7: A request that is not merged goes into the lowest-index free slot. If every slot is in use, the request is dropped. `full` is high exactly when every slot is valid.
- R8: When an incoming demand matches the bank and row of a valid prefetch entry, no new entry is allocated. That entry becomes a demand owned by the incoming core, and its arrival number does not change.
- R9: One decision is made for each clock edge at which `bus_tick` is high. The grant shows on `gnt_valid`/`gnt_idx` for the cycle after that edge, and the granted slot is freed at the same edge.
- R10: If the prefetch that an incoming demand matches is granted at the same edge, the demand is absorbed and no entry is left behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_tick | input | 1 | DRAM bus cycle strobe: make a decision at this edge |
| in_valid | input | 1 | New request present |
| in_pref | input | 1 | 1 = prefetch, 0 = demand |
| in_bank | input | BANK_W | Bank of the new request |
| in_row | input | ROW_W | Row of the new request |
| in_core | input | CORE_W | Issuing core |
| acc_pct | input | NUM_CORES*ACC_W | Per-core prefetch accuracy in percent |
| open_row | input | NUM_BANKS*ROW_W | Currently open row of each bank |
| open_vld | input | NUM_BANKS | Bank has an open row |
| full | output | 1 | All slots valid |
| gnt_valid | output | 1 | A grant was made at the last edge |
| gnt_idx | output | IDX_W | Slot index of the granted entry |

## Verification
A decision and a merge can land on the same slot in one cycle: a demand arrives at the very edge where the prefetch it matches is being granted. The bench queues a single prefetch, then raises `bus_tick` and presents the matching demand in the same cycle. It expects exactly one grant of that slot and no further grants on later ticks, which shows that the demand was absorbed and not allocated anew. A second case merges into a prefetch that is not issued, and checks that the promoted entry gains critical status while keeping its older place in arrival order.

// File: rtl/acc_sched_pkg.sv
package acc_sched_pkg;

    localparam int DEF_ENTRIES   = 8;
    localparam int DEF_BANKS     = 4;
    localparam int DEF_CORES     = 4;
    localparam int DEF_ROW_W     = 8;
    localparam int DEF_SEQ_W     = 8;
    localparam int DEF_ACC_W     = 7;
    localparam int DEF_PROMO_PCT = 85;

    typedef enum logic {
        KIND_DEMAND = 1'b0,
        KIND_PREF   = 1'b1
    } req_kind_e;

    typedef struct packed {
        logic crit;
        logic hit;
        logic urg;
    } prio_t;

    // Precedence key: critical outranks row hit, which outranks urgent.
    function automatic logic [2:0] prio_key(prio_t p);
        return {p.crit, p.hit, p.urg};
    endfunction

endpackage

// File: rtl/sched_classify.sv
module sched_classify
    import acc_sched_pkg::*;
#(
    parameter int NUM_BANKS = DEF_BANKS,
    parameter int NUM_CORES = DEF_CORES,
    parameter int ROW_W     = DEF_ROW_W,
    parameter int ACC_W     = DEF_ACC_W,
    parameter int PROMO_PCT = DEF_PROMO_PCT,
    parameter int BANK_W    = $clog2(NUM_BANKS),
    parameter int CORE_W    = $clog2(NUM_CORES)
) (
    input  req_kind_e                    kind,
    input  logic [BANK_W-1:0]            bank,
    input  logic [ROW_W-1:0]             row,
    input  logic [CORE_W-1:0]            core,
    input  logic [NUM_CORES*ACC_W-1:0]   acc_pct,
    input  logic [NUM_BANKS*ROW_W-1:0]   open_row,
    input  logic [NUM_BANKS-1:0]         open_vld,
    output prio_t                        prio
);

    logic [ACC_W-1:0] core_acc;
    logic             acc_high;
    logic             row_match;

    always_comb begin
        core_acc  = acc_pct[int'(core)*ACC_W +: ACC_W];
        acc_high  = (core_acc >= ACC_W'(PROMO_PCT));
        row_match = open_vld[bank] && (open_row[int'(bank)*ROW_W +: ROW_W] == row);

        prio.crit = (kind == KIND_DEMAND) || acc_high;
        prio.hit  = row_match;
        prio.urg  = (kind == KIND_DEMAND) && !acc_high;
    end

endmodule

// File: rtl/sched_pick.sv
module sched_pick
    import acc_sched_pkg::*;
#(
    parameter int NUM_ENTRIES = DEF_ENTRIES,
    parameter int SEQ_W       = DEF_SEQ_W,
    parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic [NUM_ENTRIES-1:0] vld,
    input  prio_t                  prio [NUM_ENTRIES],
    input  logic [SEQ_W-1:0]       seq  [NUM_ENTRIES],
    output logic                   win_vld,
    output logic [IDX_W-1:0]       win_idx
);

    // Sequence numbers wrap; a is older than b if (a - b) is negative.
    function automatic logic older(logic [SEQ_W-1:0] a, logic [SEQ_W-1:0] b);
        logic [SEQ_W-1:0] d;
        d = a - b;
        return d[SEQ_W-1];
    endfunction

    logic [2:0]       best_key;
    logic [SEQ_W-1:0] best_seq;

    always_comb begin
        win_vld  = 1'b0;
        win_idx  = '0;
        best_key = '0;
        best_seq = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (vld[i]) begin
                if (!win_vld
                    || (prio_key(prio[i]) > best_key)
                    || ((prio_key(prio[i]) == best_key) && older(seq[i], best_seq))) begin
                    win_vld  = 1'b1;
                    win_idx  = IDX_W'(i);
                    best_key = prio_key(prio[i]);
                    best_seq = seq[i];
                end
            end
        end
    end

endmodule

// File: rtl/slot_find.sv
module slot_find #(
    parameter int NUM_ENTRIES = 8,
    parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic [NUM_ENTRIES-1:0] vld,
    output logic                   free_vld,
    output logic [IDX_W-1:0]       free_idx
);

    always_comb begin
        free_vld = 1'b0;
        free_idx = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                free_vld = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/acc_sched.sv
module acc_sched
    import acc_sched_pkg::*;
#(
    parameter int NUM_ENTRIES = DEF_ENTRIES,
    parameter int NUM_BANKS   = DEF_BANKS,
    parameter int NUM_CORES   = DEF_CORES,
    parameter int ROW_W       = DEF_ROW_W,
    parameter int SEQ_W       = DEF_SEQ_W,
    parameter int ACC_W       = DEF_ACC_W,
    parameter int PROMO_PCT   = DEF_PROMO_PCT,
    localparam int IDX_W      = $clog2(NUM_ENTRIES),
    localparam int BANK_W     = $clog2(NUM_BANKS),
    localparam int CORE_W     = $clog2(NUM_CORES)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bus_tick,
    input  logic                       in_valid,
    input  logic                       in_pref,
    input  logic [BANK_W-1:0]          in_bank,
    input  logic [ROW_W-1:0]           in_row,
    input  logic [CORE_W-1:0]          in_core,
    input  logic [NUM_CORES*ACC_W-1:0] acc_pct,
    input  logic [NUM_BANKS*ROW_W-1:0] open_row,
    input  logic [NUM_BANKS-1:0]       open_vld,
    output logic                       full,
    output logic                       gnt_valid,
    output logic [IDX_W-1:0]           gnt_idx
);

    logic [NUM_ENTRIES-1:0] vld_q;
    req_kind_e              kind_q [NUM_ENTRIES];
    logic [BANK_W-1:0]      bank_q [NUM_ENTRIES];
    logic [ROW_W-1:0]       row_q  [NUM_ENTRIES];
    logic [CORE_W-1:0]      core_q [NUM_ENTRIES];
    logic [SEQ_W-1:0]       seq_q  [NUM_ENTRIES];
    logic [SEQ_W-1:0]       seq_ctr;

    prio_t                  prio   [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] crit_vec;
    logic [NUM_ENTRIES-1:0] match;

    logic             win_vld;
    logic [IDX_W-1:0] win_idx;
    logic             free_vld;
    logic [IDX_W-1:0] free_idx;

    logic issue;
    logic merge;
    logic alloc;

    // Per-entry class bits and merge compare.
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
        sched_classify #(
            .NUM_BANKS (NUM_BANKS),
            .NUM_CORES (NUM_CORES),
            .ROW_W     (ROW_W),
            .ACC_W     (ACC_W),
            .PROMO_PCT (PROMO_PCT),
            .BANK_W    (BANK_W),
            .CORE_W    (CORE_W)
        ) u_cls (
            .kind     (kind_q[g]),
            .bank     (bank_q[g]),
            .row      (row_q[g]),
            .core     (core_q[g]),
            .acc_pct  (acc_pct),
            .open_row (open_row),
            .open_vld (open_vld),
            .prio     (prio[g])
        );

        assign crit_vec[g] = prio[g].crit;
        assign match[g]    = vld_q[g] && (kind_q[g] == KIND_PREF)
                             && (bank_q[g] == in_bank) && (row_q[g] == in_row);
    end

    sched_pick #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .SEQ_W       (SEQ_W),
        .IDX_W       (IDX_W)
    ) u_pick (
        .vld     (vld_q),
        .prio    (prio),
        .seq     (seq_q),
        .win_vld (win_vld),
        .win_idx (win_idx)
    );

    slot_find #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .IDX_W       (IDX_W)
    ) u_free (
        .vld      (vld_q),
        .free_vld (free_vld),
        .free_idx (free_idx)
    );

    always_comb begin
        issue = bus_tick && win_vld;
        merge = in_valid && !in_pref && (|match);
        alloc = in_valid && !merge && free_vld;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q     <= '0;
            seq_ctr   <= '0;
            gnt_valid <= 1'b0;
            gnt_idx   <= '0;
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                kind_q[i] <= KIND_DEMAND;
                bank_q[i] <= '0;
                row_q[i]  <= '0;
                core_q[i] <= '0;
                seq_q[i]  <= '0;
            end
        end else begin
            gnt_valid <= issue;
            if (issue) begin
                gnt_idx        <= win_idx;
                vld_q[win_idx] <= 1'b0;
            end
            // Promotion keeps the arrival number; a slot freed by the
            // grant in this cycle simply absorbs the demand.
            if (merge) begin
                for (int i = 0; i < NUM_ENTRIES; i++) begin
                    if (match[i]) begin
                        kind_q[i] <= KIND_DEMAND;
                        core_q[i] <= in_core;
                    end
                end
            end
            if (alloc) begin
                vld_q[free_idx]  <= 1'b1;
                kind_q[free_idx] <= in_pref ? KIND_PREF : KIND_DEMAND;
                bank_q[free_idx] <= in_bank;
                row_q[free_idx]  <= in_row;
                core_q[free_idx] <= in_core;
                seq_q[free_idx]  <= seq_ctr;
                seq_ctr          <= seq_ctr + 1'b1;
            end
        end
    end

    assign full = &vld_q;

endmodule

// File: rtl/acc_sched_chk.sv
module acc_sched_chk #(
    parameter int NUM_ENTRIES = 8,
    parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   bus_tick,
    input logic                   gnt_valid,
    input logic [IDX_W-1:0]       gnt_idx,
    input logic [NUM_ENTRIES-1:0] vld_q,
    input logic [NUM_ENTRIES-1:0] crit_vec
);

    logic [NUM_ENTRIES-1:0] prev_vld;
    logic [NUM_ENTRIES-1:0] prev_crit;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_vld  <= '0;
            prev_crit <= '0;
        end else begin
            prev_vld  <= vld_q;
            prev_crit <= crit_vec & vld_q;
        end
    end

    // R1
    empty_nogrant_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_tick && (vld_q == '0)) |=> !gnt_valid);

    // R1
    grant_was_valid_chk: assert property (@(posedge clk) disable iff (rst)
        gnt_valid |-> prev_vld[gnt_idx]);

    // R9
    grant_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
        gnt_valid |-> $past(bus_tick));

    // R9
    granted_freed_chk: assert property (@(posedge clk) disable iff (rst)
        gnt_valid |-> !vld_q[gnt_idx]);

    // R4
    critical_first_chk: assert property (@(posedge clk) disable iff (rst)
        (gnt_valid && (prev_crit != '0)) |-> prev_crit[gnt_idx]);

endmodule

bind acc_sched acc_sched_chk #(
    .NUM_ENTRIES (NUM_ENTRIES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_tick  (bus_tick),
    .gnt_valid (gnt_valid),
    .gnt_idx   (gnt_idx),
    .vld_q     (vld_q),
    .crit_vec  (crit_vec)
);

// File: tb/sim_acc_sched.sv
module sim_acc_sched;

    localparam int CLK_PERIOD = 10;
    localparam int NE    = 8;
    localparam int NB    = 4;
    localparam int NC    = 4;
    localparam int ROW_W = 8;
    localparam int ACC_W = 7;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_tick = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_pref = 1'b0;
    logic [1:0]        in_bank = '0;
    logic [ROW_W-1:0]  in_row = '0;
    logic [1:0]        in_core = '0;
    logic [NC*ACC_W-1:0] acc_pct = '0;
    logic [NB*ROW_W-1:0] open_row = '0;
    logic [NB-1:0]     open_vld = '0;
    logic              full;
    logic              gnt_valid;
    logic [2:0]        gnt_idx;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    int    exp_idx [$];
    string exp_tag [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_sched u0 (
        .clk(clk), .rst(rst), .bus_tick(bus_tick),
        .in_valid(in_valid), .in_pref(in_pref), .in_bank(in_bank),
        .in_row(in_row), .in_core(in_core), .acc_pct(acc_pct),
        .open_row(open_row), .open_vld(open_vld),
        .full(full), .gnt_valid(gnt_valid), .gnt_idx(gnt_idx)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic expect_gnt(input int idx, input string tag);
        exp_idx.push_back(idx);
        exp_tag.push_back(tag);
    endtask

    // Monitor: every grant is compared against the scoreboard queue.
    always @(negedge clk) begin
        if (!rst && gnt_valid) begin
            if (exp_idx.size() == 0) begin
                check(1'b0, "R9 unexpected grant", int'(gnt_idx), -1);
            end else begin
                int    e;
                string t;
                e = exp_idx.pop_front();
                t = exp_tag.pop_front();
                check(int'(gnt_idx) == e, t, int'(gnt_idx), e);
            end
        end
    end

    task automatic set_acc(input int c, input int pct);
        acc_pct[c*ACC_W +: ACC_W] = ACC_W'(pct);
    endtask

    task automatic ins(input bit pref, input int bank, input int row, input int core);
        in_valid = 1'b1;
        in_pref  = pref;
        in_bank  = 2'(bank);
        in_row   = ROW_W'(row);
        in_core  = 2'(core);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic tick(input int n);
        bus_tick = 1'b1;
        repeat (n) @(negedge clk);
        bus_tick = 1'b0;
    endtask

    task automatic drained(input string tag);
        @(negedge clk);
        check(exp_idx.size() == 0, tag, exp_idx.size(), 0);
        exp_idx.delete();
        exp_tag.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(gnt_valid == 1'b0, "R1 reset grant", gnt_valid, 0);
        check(full == 1'b0, "R7 reset full", full, 0);

        set_acc(0, 50);
        set_acc(1, 90);
        set_acc(2, 84);
        set_acc(3, 85);
        open_row[0*ROW_W +: ROW_W] = 8'd5;
        open_vld = 4'b0001;

        // R1: ticks with an empty pool give nothing
        tick(2);
        drained("R1 empty");

        // R4/R2: low-accuracy prefetch row hit loses to demand
        ins(1'b1, 0, 5, 0);
        ins(1'b0, 1, 3, 1);
        expect_gnt(1, "R4 critical over row hit");
        expect_gnt(0, "R2 low-acc prefetch last");
        tick(3);
        drained("R4 drain a");

        // R4: row hit beats urgent
        ins(1'b0, 1, 9, 0);
        ins(1'b0, 0, 5, 1);
        expect_gnt(1, "R4 row hit over urgent");
        expect_gnt(0, "R4 urgent second");
        tick(3);
        drained("R4 drain b");

        // R3: urgent beats older non-urgent demand
        ins(1'b0, 2, 1, 1);
        ins(1'b0, 2, 2, 0);
        expect_gnt(1, "R3 urgent over age");
        expect_gnt(0, "R3 non-urgent second");
        tick(3);
        drained("R3 drain");

        // R2: accuracy 85 promotes, 84 does not
        ins(1'b1, 3, 7, 2);
        ins(1'b1, 3, 8, 3);
        expect_gnt(1, "R2 threshold 85 critical");
        expect_gnt(0, "R2 threshold 84 not critical");
        tick(3);
        drained("R2 drain");

        // R5: no open row in bank 0 -> no hit, then with open row -> hit
        open_vld = 4'b0000;
        ins(1'b0, 2, 0, 1);
        ins(1'b0, 0, 5, 1);
        expect_gnt(0, "R5 closed bank no hit");
        expect_gnt(1, "R5 closed bank no hit second");
        tick(3);
        drained("R5 drain a");
        open_vld = 4'b0001;
        ins(1'b0, 2, 0, 1);
        ins(1'b0, 0, 5, 1);
        expect_gnt(1, "R5 open bank hit");
        expect_gnt(0, "R5 open bank second");
        tick(3);
        drained("R5 drain b");

        // R6: age wins over slot index after reuse of slot 0
        ins(1'b0, 1, 10, 1);
        ins(1'b0, 1, 11, 1);
        ins(1'b0, 1, 12, 1);
        expect_gnt(0, "R6 first oldest");
        tick(1);
        ins(1'b0, 1, 13, 1);
        expect_gnt(1, "R6 age order");
        expect_gnt(2, "R6 age order");
        expect_gnt(0, "R6 reused slot newest");
        tick(4);
        drained("R6 drain");

        // R8: demand merges into queued prefetch, keeps older arrival
        ins(1'b1, 2, 4, 0);
        ins(1'b0, 1, 1, 1);
        ins(1'b0, 2, 4, 1);
        expect_gnt(0, "R8 promoted keeps age");
        expect_gnt(1, "R8 second");
        tick(4);
        drained("R8 no extra entry");

        // R10: merge into the entry granted at the same edge
        ins(1'b1, 1, 2, 0);
        bus_tick = 1'b1;
        in_valid = 1'b1;
        in_pref  = 1'b0;
        in_bank  = 2'd1;
        in_row   = 8'd2;
        in_core  = 2'd1;
        expect_gnt(0, "R10 same-edge grant");
        @(negedge clk);
        in_valid = 1'b0;
        bus_tick = 1'b0;
        tick(3);
        drained("R10 demand absorbed");

        // R7: fill, drop extra, drain in arrival order
        open_vld = 4'b0000;
        for (int k = 0; k < NE; k++) ins(1'b0, k % 4, 30 + k, 1);
        check(full == 1'b1, "R7 full set", full, 1);
        ins(1'b0, 0, 99, 1);
        for (int k = 0; k < NE; k++) expect_gnt(k, "R7 fill order");
        tick(NE + 2);
        drained("R7 extra dropped");
        check(full == 1'b0, "R7 full cleared", full, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(1'b0, "R9 watchdog", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule